// File: doc/BRIEF.md
# Serial Transmit Engine with Holding Queue

This block is the transmit side of an asynchronous serial port. A host hands it bytes one at a time through a write strobe. The block turns each byte into a serial frame on `txd`. The frame has a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional odd or even parity bit, then one or two high stop bits. Between frames the line rests high.

The block has two queueing modes. In single-register mode (`fifo_en` = 0, which is also the mode out of reset) there is one holding register in front of the shift register. In queued mode (`fifo_en` = 1) a first-in first-out queue of `FIFO_DEPTH` bytes sits in front of the shift register, and a write to a full queue is dropped. The mode is registered, so it takes effect one cycle after `fifo_en` changes. Any change of mode empties the queue, and so does a pulse on `fifo_clr`. The bit period is `baud_tick` divided by an oversampling factor of 16, 8 or 4.

The block drives two status flags. The holding-empty flag is high when nothing waits in front of the shift register. The transmitter-empty flag is high when, in addition, no frame is in progress. It also drives a transmit-empty interrupt. In single-register mode the interrupt follows the holding-empty flag. In queued mode it is an event flag: it is set when the fill level falls below a selectable trigger level, and again when the queue runs dry.

The serializer is a state machine with six states:
- `TX_IDLE`: the line is high. If data is waiting, the machine pops it into the shift register and moves to `TX_ARM`.
- `TX_ARM`: the line is high. On the next bit tick the machine moves to `TX_START`.
- `TX_START`: the line is low for one bit period, then the machine moves to `TX_DATA`.
- `TX_DATA`: the data bits are shifted out one per bit period. After the last bit the machine moves to `TX_PARITY` if parity is enabled, otherwise to `TX_STOP`.
- `TX_PARITY`: the parity bit is sent for one bit period, then the machine moves to `TX_STOP`.
- `TX_STOP`: the line is high for one or two bit periods. On the last stop tick the machine pops the next byte and goes straight to `TX_START` if data is waiting. Otherwise it returns to `TX_IDLE`.

Top module: `uart_tx_core`

## Requirements
- R1: During and after reset, before any write, `txd` is 1, `thr_empty` is 1 and `tx_empty` is 1, and `thre_irq` is 0 while `thre_ie` is 0.
- R2: Each frame is one low start bit, then N = 5 + `word_len` data bits (`word_len` 0..3 gives 5..8 bits), least significant bit first, then the stop bits (1 when `two_stop` = 0, 2 when `two_stop` = 1). Data bits above N are not sent. `txd` is 1 whenever `tx_empty` is 1.
- R3: When `parity_en` = 1, one parity bit follows the data bits. With `parity_even` = 1 it makes the count of ones over the data bits and the parity bit even; with `parity_even` = 0 it makes that count odd.
- R4: Every bit lasts F rising edges of `baud_tick`, where `os_sel` 00 gives F = 16, 01 gives F = 8, 10 gives F = 4 and 11 gives F = 16. A start bit begins only on a bit-clock boundary.
- R5: In single-register mode, a written byte moves into the shift register in the cycle after the write whenever the serializer is idle, and `thr_empty` returns to 1 at that point. While one byte waits in the holding register, further writes are dropped.
- R6: In queued mode, up to `FIFO_DEPTH` bytes wait in front of the shift register and go out in write order. A write to a full queue is dropped.
- R7: In queued mode, `thr_empty` is 1 exactly when the queue holds no byte.
- R8: `tx_empty` is 1 only when nothing is waiting and the serializer is in `TX_IDLE`.
- R9: In single-register mode, `thre_irq` equals `thr_empty` while `thre_ie` = 1.
- R10: In queued mode, a latched interrupt is set when a pop drops the fill level from the trigger level T to T-1, or from 1 to 0. An accepted write clears it. `trig_sel` 00, 01, 10 and 11 give T = DEPTH/8, DEPTH/4, DEPTH/2 and DEPTH-DEPTH/8.
- R11: `thre_irq` is 0 whenever `thre_ie` is 0.
- R12: A pulse on `fifo_clr` discards every waiting byte and sets `thr_empty` on the next cycle. The frame already in the shift register still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at the oversampled rate |
| fifo_en | input | 1 | 1 selects queued mode, 0 selects single-register mode |
| os_sel | input | 2 | Oversampling factor select |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Adds a parity bit |
| parity_even | input | 1 | 1 for even parity, 0 for odd parity |
| two_stop | input | 1 | 1 for two stop bits |
| trig_sel | input | 2 | Trigger level select for queued mode |
| thre_ie | input | 1 | Interrupt enable |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to send |
| fifo_clr | input | 1 | Discards the waiting bytes |
| txd | output | 1 | Serial output, idles high |
| thr_empty | output | 1 | Nothing waits in front of the shift register |
| tx_empty | output | 1 | Nothing waits and no frame is in progress |
| thre_irq | output | 1 | Transmit-empty interrupt |

## Verification
The bench builds the block with `FIFO_DEPTH` = 16. This lets it fill the queue to the drop point with a few writes, and it gives trigger levels of 2, 4, 8 and 14, so both interrupt events are reached after a handful of frames. It can hold the queue full by stopping `baud_tick`. It also runs random frame formats with tick spacings of 1 and 2 cycles and all four oversampling codes. A decoder in the bench measures bit lengths in cycles, so a wrong bit period shows up as corrupted data.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int BYTE_W = 8;
    localparam int OSC_W  = 4;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_ARM,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_on;
        logic       par_even;
        logic       stop2;
    } frame_cfg_t;

    // Terminal count of the oversampling divider: factor minus one.
    function automatic logic [OSC_W-1:0] os_limit(input logic [1:0] sel);
        unique case (sel)
            2'b01:   os_limit = 4'd7;
            2'b10:   os_limit = 4'd3;
            default: os_limit = 4'd15;
        endcase
    endfunction

    // Mask that keeps the low 5..8 bits of a byte.
    function automatic logic [BYTE_W-1:0] len_mask(input logic [1:0] wlen);
        len_mask = 8'hFF >> (2'd3 - wlen);
    endfunction

endpackage

// File: rtl/uart_tx_bitclk.sv
module uart_tx_bitclk
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic [1:0] os_sel,
    output logic       bit_tick
);

    logic [OSC_W-1:0] cnt_q;
    logic [OSC_W-1:0] limit;
    logic             wrap;

    assign limit    = os_limit(os_sel);
    assign wrap     = (cnt_q >= limit);
    assign bit_tick = baud_tick && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (baud_tick) begin
            if (wrap) cnt_q <= '0;
            else      cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       single,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               pop_data,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    assign empty    = (cnt_q == '0);
    assign full     = single ? !empty : (cnt_q == CW'(DEPTH));
    assign push_ok  = push && !full && !flush;
    assign pop_ok   = pop && !empty && !flush;
    assign pop_data = mem[rd_ptr];
    assign count    = cnt_q;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              have_data,
    input  logic [BYTE_W-1:0] load_data,
    input  frame_cfg_t        cfg_in,
    output logic              pop,
    output logic              txd,
    output logic              busy
);

    tx_state_e         state_q, state_d;
    frame_cfg_t        cfg_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [2:0]        bit_cnt_q;
    logic              stop_cnt_q;
    logic              par_q;
    logic              last_data;
    logic              last_stop;
    logic [BYTE_W-1:0] masked;

    assign masked    = load_data & len_mask(cfg_in.wlen);
    assign last_data = (bit_cnt_q == ({1'b0, cfg_q.wlen} + 3'd4));
    assign last_stop = !cfg_q.stop2 || stop_cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:   if (have_data) state_d = TX_ARM;
            TX_ARM:    if (bit_tick)  state_d = TX_START;
            TX_START:  if (bit_tick)  state_d = TX_DATA;
            TX_DATA:   if (bit_tick && last_data)
                           state_d = cfg_q.par_on ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_tick)  state_d = TX_STOP;
            TX_STOP:   if (bit_tick && last_stop)
                           state_d = have_data ? TX_START : TX_IDLE;
            default:   state_d = TX_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        txd  = 1'b1;
        pop  = 1'b0;
        busy = 1'b1;
        unique case (state_q)
            TX_IDLE: begin
                busy = 1'b0;
                pop  = have_data;
            end
            TX_ARM:    txd = 1'b1;
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg_q[0];
            TX_PARITY: txd = par_q;
            TX_STOP:   pop = bit_tick && last_stop && have_data;
            default:   busy = 1'b0;
        endcase
    end

    // Shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            shreg_q    <= '0;
            bit_cnt_q  <= '0;
            stop_cnt_q <= 1'b0;
            par_q      <= 1'b0;
        end else if (pop) begin
            cfg_q      <= cfg_in;
            shreg_q    <= masked;
            bit_cnt_q  <= '0;
            stop_cnt_q <= 1'b0;
            par_q      <= cfg_in.par_even ? (^masked) : ~(^masked);
        end else if (bit_tick) begin
            if (state_q == TX_DATA) begin
                shreg_q   <= shreg_q >> 1;
                bit_cnt_q <= bit_cnt_q + 3'd1;
            end
            if (state_q == TX_STOP) stop_cnt_q <= 1'b1;
        end
    end

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        baud_tick,
    input  logic        fifo_en,
    input  logic [1:0]  os_sel,
    input  logic [1:0]  word_len,
    input  logic        parity_en,
    input  logic        parity_even,
    input  logic        two_stop,
    input  logic [1:0]  trig_sel,
    input  logic        thre_ie,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        fifo_clr,
    output logic        txd,
    output logic        thr_empty,
    output logic        tx_empty,
    output logic        thre_irq
);

    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;
    localparam logic [CNT_W-1:0] TRIG_A = CNT_W'(FIFO_DEPTH / 8);
    localparam logic [CNT_W-1:0] TRIG_B = CNT_W'(FIFO_DEPTH / 4);
    localparam logic [CNT_W-1:0] TRIG_C = CNT_W'(FIFO_DEPTH / 2);
    localparam logic [CNT_W-1:0] TRIG_D = CNT_W'(FIFO_DEPTH - FIFO_DEPTH / 8);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    logic              mode_q;
    logic              flush;
    logic              bit_tick;
    logic              tx_pop;
    logic              tx_busy;
    logic              fifo_full, fifo_empty;
    logic [CNT_W-1:0]  fifo_count;
    logic [BYTE_W-1:0] fifo_head;
    logic [CNT_W-1:0]  trig_lvl;
    logic              push_ok;
    logic              irq_event;
    logic              irq_pend_q;
    frame_cfg_t        cfg;

    assign cfg = '{wlen: word_len, par_on: parity_en, par_even: parity_even, stop2: two_stop};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= fifo_en;
    end

    assign flush = fifo_clr || (fifo_en != mode_q);

    uart_tx_bitclk u_bitclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .os_sel    (os_sel),
        .bit_tick  (bit_tick)
    );

    uart_tx_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .single    (!mode_q),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (tx_pop),
        .pop_data  (fifo_head),
        .count     (fifo_count),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    uart_tx_serializer u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .have_data (!fifo_empty && !flush),
        .load_data (fifo_head),
        .cfg_in    (cfg),
        .pop       (tx_pop),
        .txd       (txd),
        .busy      (tx_busy)
    );

    always_comb begin
        unique case (trig_sel)
            2'b00:   trig_lvl = TRIG_A;
            2'b01:   trig_lvl = TRIG_B;
            2'b10:   trig_lvl = TRIG_C;
            default: trig_lvl = TRIG_D;
        endcase
    end

    assign push_ok   = wr_en && !fifo_full && !flush;
    assign irq_event = mode_q && tx_pop && !push_ok &&
                       ((fifo_count == trig_lvl) || (fifo_count == ONE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         irq_pend_q <= 1'b0;
        else if (flush)     irq_pend_q <= 1'b0;
        else if (irq_event) irq_pend_q <= 1'b1;
        else if (push_ok)   irq_pend_q <= 1'b0;
    end

    assign thr_empty = fifo_empty;
    assign tx_empty  = fifo_empty && !tx_busy;
    assign thre_irq  = thre_ie && (mode_q ? irq_pend_q : fifo_empty);

endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          txd,
    input logic          thr_empty,
    input logic          tx_empty,
    input logic          thre_ie,
    input logic          thre_irq,
    input logic          fifo_clr,
    input logic          wr_en,
    input logic          bit_tick,
    input logic          fifo_full,
    input logic          tx_pop,
    input logic          flush,
    input logic [CW-1:0] count
);

    p_idle_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);

    p_start_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> $past(bit_tick));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fifo_full && !tx_pop && !flush) |=> fifo_full);

    p_txempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> thr_empty);

    p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !thre_ie |-> !thre_irq);

    p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> thr_empty);

endmodule

bind uart_tx_core uart_tx_checker #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .txd       (txd),
    .thr_empty (thr_empty),
    .tx_empty  (tx_empty),
    .thre_ie   (thre_ie),
    .thre_irq  (thre_irq),
    .fifo_clr  (fifo_clr),
    .wr_en     (wr_en),
    .bit_tick  (bit_tick),
    .fifo_full (fifo_full),
    .tx_pop    (tx_pop),
    .flush     (flush),
    .count     (fifo_count)
);

// File: tb/sim_uart_tx_core.sv
module sim_uart_tx_core;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       baud_tick;
    logic       fifo_en;
    logic [1:0] os_sel;
    logic [1:0] word_len;
    logic       parity_en;
    logic       parity_even;
    logic       two_stop;
    logic [1:0] trig_sel;
    logic       thre_ie;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       fifo_clr;
    logic       txd, thr_empty, tx_empty, thre_irq;

    uart_tx_core #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .fifo_en(fifo_en),
        .os_sel(os_sel), .word_len(word_len), .parity_en(parity_en),
        .parity_even(parity_even), .two_stop(two_stop), .trig_sel(trig_sel),
        .thre_ie(thre_ie), .wr_en(wr_en), .wr_data(wr_data), .fifo_clr(fifo_clr),
        .txd(txd), .thr_empty(thr_empty), .tx_empty(tx_empty), .thre_irq(thre_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] exp_q [0:1023];
    int         wr_i = 0;
    int         rd_i = 0;
    int         frames_done = 0;
    int         tick_gap = 1;
    bit         tick_run = 1'b0;
    bit         mon_en = 1'b0;
    int         tcnt = 0;

    function automatic int os_fac(input logic [1:0] s);
        case (s)
            2'b01:   return 8;
            2'b10:   return 4;
            default: return 16;
        endcase
    endfunction

    function automatic logic [7:0] mask_of(input logic [1:0] wl);
        return 8'hFF >> (3 - int'(wl));
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input logic even);
        return even ? (^d) : ~(^d);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Baud tick source, one pulse every tick_gap cycles
    initial begin
        baud_tick = 1'b0;
        forever begin
            @(negedge clk);
            if (!tick_run) baud_tick = 1'b0;
            else begin
                tcnt++;
                baud_tick = ((tcnt % tick_gap) == 0);
            end
        end
    end

    // Serial decoder: samples each bit once per bit period
    initial begin
        wait (mon_en);
        forever begin
            @(negedge clk);
            if (txd === 1'b0) begin : frame
                int         per;
                int         nbits;
                int         nstop;
                logic [7:0] gd;
                logic       gp;
                bit         stop_ok;
                per     = os_fac(os_sel) * tick_gap;
                nbits   = 5 + int'(word_len);
                nstop   = two_stop ? 2 : 1;
                gd      = 8'h00;
                gp      = 1'b0;
                stop_ok = 1'b1;
                for (int i = 0; i < nbits; i++) begin
                    repeat (per) @(negedge clk);
                    gd[i] = txd;
                end
                if (parity_en) begin
                    repeat (per) @(negedge clk);
                    gp = txd;
                end
                for (int s = 0; s < nstop; s++) begin
                    repeat (per) @(negedge clk);
                    if (txd !== 1'b1) stop_ok = 1'b0;
                end
                if (rd_i == wr_i) begin
                    chk(1'b0, "R6 unexpected frame", int'(gd), -1);
                end else begin
                    chk(gd == exp_q[rd_i], "R2 R4 data bits", int'(gd), int'(exp_q[rd_i]));
                    if (parity_en)
                        chk(gp == exp_par(exp_q[rd_i], parity_even), "R3 parity bit",
                            int'(gp), int'(exp_par(exp_q[rd_i], parity_even)));
                    rd_i++;
                end
                chk(stop_ok, "R2 stop bits", int'(stop_ok), 1);
                frames_done++;
            end
        end
    end

    task automatic wr_byte(input logic [7:0] d, input bit accept);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        if (accept) begin
            exp_q[wr_i] = d & mask_of(word_len);
            wr_i++;
        end
    endtask

    task automatic drain();
        int lim;
        lim = 0;
        while (!(rd_i == wr_i && tx_empty === 1'b1) && lim < 60000) begin
            @(negedge clk);
            lim++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_irq(input int base, input int want, input string req);
        int  lim;
        bit  seen;
        lim  = 0;
        seen = 1'b0;
        while (!seen && lim < 20000) begin
            @(negedge clk);
            lim++;
            if (thre_irq === 1'b1) begin
                seen = 1'b1;
                chk(frames_done - base == want, req, frames_done - base, want);
            end
        end
        if (!seen) chk(1'b0, req, 0, 1);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd2024));
        rst_n = 1'b0; fifo_en = 1'b0; os_sel = 2'b10; word_len = 2'b11;
        parity_en = 1'b0; parity_even = 1'b0; two_stop = 1'b0; trig_sel = 2'b00;
        thre_ie = 1'b0; wr_en = 1'b0; wr_data = 8'h00; fifo_clr = 1'b0;

        repeat (3) @(negedge clk);
        chk(txd === 1'b1 && thr_empty === 1'b1 && tx_empty === 1'b1 && thre_irq === 1'b0,
            "R1 reset outputs", {txd, thr_empty, tx_empty, thre_irq}, 4'b1110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(txd === 1'b1 && thr_empty === 1'b1 && tx_empty === 1'b1 && thre_irq === 1'b0,
            "R1 after reset", {txd, thr_empty, tx_empty, thre_irq}, 4'b1110);
        mon_en = 1'b1;

        // Single-register mode, ticks halted
        thre_ie = 1'b1;
        @(negedge clk);
        chk(thre_irq === 1'b1, "R9 irq follows empty flag", thre_irq, 1);
        wr_byte(8'hA5, 1'b1);
        chk(thr_empty === 1'b0 && thre_irq === 1'b0, "R5 R9 held after write",
            {thr_empty, thre_irq}, 0);
        @(negedge clk);
        chk(thr_empty === 1'b1 && thre_irq === 1'b1 && tx_empty === 1'b0,
            "R5 R8 moved to shifter", {thr_empty, thre_irq, tx_empty}, 3'b110);
        wr_byte(8'h3C, 1'b1);
        wr_byte(8'hFF, 1'b0);
        chk(thr_empty === 1'b0, "R5 holding full", thr_empty, 0);
        thre_ie = 1'b0;
        @(negedge clk);
        chk(thre_irq === 1'b0, "R11 irq disabled", thre_irq, 0);
        base = frames_done;
        tick_run = 1'b1;
        drain();
        chk(frames_done - base == 2, "R5 extra write dropped", frames_done - base, 2);

        // Queued mode: overfill with ticks halted
        tick_run = 1'b0;
        fifo_en  = 1'b1;
        repeat (3) @(negedge clk);
        for (int k = 0; k < DEPTH + 4; k++)
            wr_byte(8'(k * 37 + 5), k < DEPTH + 1);
        chk(thr_empty === 1'b0 && tx_empty === 1'b0, "R7 R8 flags with queue full",
            {thr_empty, tx_empty}, 0);
        base = frames_done;
        tick_run = 1'b1;
        drain();
        chk(frames_done - base == DEPTH + 1, "R6 full queue drops writes",
            frames_done - base, DEPTH + 1);
        chk(thr_empty === 1'b1 && tx_empty === 1'b1, "R7 R8 flags after drain",
            {thr_empty, tx_empty}, 2'b11);

        // Trigger crossing, T = DEPTH/4 = 4
        tick_run = 1'b0;
        thre_ie  = 1'b1;
        trig_sel = 2'b01;
        for (int k = 0; k < 9; k++) wr_byte(8'($urandom), 1'b1);
        chk(thre_irq === 1'b0, "R10 write clears interrupt", thre_irq, 0);
        base = frames_done;
        tick_run = 1'b1;
        wait_irq(base, 5, "R10 trigger crossing");
        drain();
        chk(thre_irq === 1'b1, "R10 pending held", thre_irq, 1);

        // Empty event with a high trigger, T = 14
        tick_run = 1'b0;
        trig_sel = 2'b11;
        for (int k = 0; k < 3; k++) wr_byte(8'($urandom), 1'b1);
        chk(thre_irq === 1'b0, "R10 cleared before empty", thre_irq, 0);
        base = frames_done;
        tick_run = 1'b1;
        wait_irq(base, 2, "R10 queue empty event");
        drain();
        thre_ie = 1'b0;
        @(negedge clk);
        chk(thre_irq === 1'b0, "R11 gate in queued mode", thre_irq, 0);

        // Clear discards waiting bytes
        tick_run = 1'b0;
        wr_byte(8'h81, 1'b1);
        for (int k = 0; k < 3; k++) wr_byte(8'h42, 1'b0);
        @(negedge clk);
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
        chk(thr_empty === 1'b1 && tx_empty === 1'b0, "R12 clear flags",
            {thr_empty, tx_empty}, 2'b10);
        base = frames_done;
        tick_run = 1'b1;
        drain();
        chk(frames_done - base == 1, "R12 only shifter frame sent", frames_done - base, 1);

        // Random formats
        for (int c = 0; c < 8; c++) begin
            int n;
            os_sel      = 2'($urandom);
            word_len    = 2'($urandom);
            parity_en   = 1'($urandom);
            parity_even = 1'($urandom);
            two_stop    = 1'($urandom);
            tick_gap    = 1 + int'($urandom % 2);
            repeat (3) @(negedge clk);
            n = 1 + int'($urandom % DEPTH);
            for (int k = 0; k < n; k++) wr_byte(8'($urandom), 1'b1);
            drain();
            chk(rd_i == wr_i, "R6 all bytes in order", rd_i, wr_i);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule